// File: doc/BRIEF.md
# Strided Interleave DMA Sequencer

This block sequences one interleaved DMA channel that serves a scratchpad. It takes a start byte address, a total quadword count, a block length and a gap length, all in quadwords. In strided mode it requests one block of quadwords at the current address. It waits for the data path to accept the block, then jumps over the gap. It repeats this until the count is used up, then clears its busy flag and pulses an interrupt. It moves no data. It only produces the address and length of each block, and it tracks the address and the remaining count.

When the mode is contiguous, or the channel is not a scratchpad channel, or the block or gap length is zero, the same start runs as one plain transfer of the whole count. A strided total that is not a whole number of blocks is refused before any request is issued, and an error flag is raised.

Top module: `strided_dma_seq`

## Requirements
- R1: After reset, busy, blk_req, irq and len_err are 0, and cur_addr and rem_qwc are 0.
- R2: A start pulse is taken only while the sequencer is idle and mode is 0 (contiguous) or 2 (strided). Mode values 1 and 3 are ignored. A start while busy is ignored. An ignored start changes neither cur_addr nor rem_qwc.
- R3: Strided mode is used when mode is 2, scratch_ch is 1, and blk_size, gap_size and total_qwc are all non-zero. Each request then has blk_qwc equal to blk_size and blk_addr equal to cur_addr.
- R4: One cycle after a request is accepted (blk_req and blk_ack both high at a clock edge), cur_addr has grown by 16 times blk_qwc and rem_qwc has shrunk by blk_qwc.
- R5: In strided mode, each accepted block is followed by a one-cycle gap phase with no request. At the end of that phase cur_addr has grown by 16 times gap_size.
- R6: When rem_qwc is 0 at the end of a gap phase, or after the single block of a contiguous run, busy falls and irq is high for exactly one cycle. irq is never high while busy is high.
- R7: In every other accepted case (mode 0, mode 2 on a non-scratchpad channel, or a zero block or gap size), exactly one request of total_qwc quadwords is made.
- R8: A contiguous run with total_qwc of 0 still moves one quadword, so rem_qwc wraps to all ones.
- R9: A strided start whose total_qwc is not a multiple of blk_size sets len_err, issues no request, and leaves busy low. len_err is cleared by the next accepted start.
- R10: blk_req stays high, with blk_addr and blk_qwc stable, until blk_ack is seen.
- R11: The low four bits of start_addr are ignored, so every blk_addr is 16-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start command |
| mode | input | 2 | 0 contiguous, 2 strided, 1 and 3 ignored |
| scratch_ch | input | 1 | Channel is a scratchpad channel |
| start_addr | input | AW | Start byte address |
| total_qwc | input | CW | Total quadwords to move |
| blk_size | input | SW | Quadwords per block in strided mode |
| gap_size | input | SW | Quadwords skipped after each block |
| blk_req | output | 1 | Block request to the data path |
| blk_addr | output | AW | Byte address of the requested block |
| blk_qwc | output | CW | Quadwords in the requested block |
| blk_ack | input | 1 | Data path accepts the request |
| cur_addr | output | AW | Current byte address |
| rem_qwc | output | CW | Remaining quadword count |
| busy | output | 1 | Run in progress |
| irq | output | 1 | One-cycle completion interrupt |
| len_err | output | 1 | Strided length refused |

## Verification
A wrong phase register would show at once. The request would appear in a gap cycle or go missing after one, and the next blk_addr would be off by the gap width. A corrupt address or count register shows within one cycle of an accept, on cur_addr or rem_qwc. A bad stop test shows as an irq that comes too early or a run that never ends, both at the final gap phase. A faulty length check shows in the cycle after start, as len_err or as a request.

// File: rtl/sdma_il_pkg.sv
// Shared definitions for the strided DMA sequencer.
// Assumes byte addresses with 16-byte quadwords.
package sdma_il_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_SKIP = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    localparam logic [1:0] MODE_LINEAR = 2'd0;
    localparam logic [1:0] MODE_STRIDE = 2'd2;
    localparam int         QW_SHIFT    = 4;
endpackage

// File: rtl/sdma_cfg_check.sv
// Decodes the programmed configuration at start time: whether the mode is
// accepted, whether the strided pattern applies, and whether the total is a
// whole number of blocks. Purely combinational. Assumes SW < CW.
module sdma_cfg_check #(
    parameter int CW = 16,
    parameter int SW = 8
) (
    input  logic [1:0]    mode,
    input  logic          scratch_ch,
    input  logic [CW-1:0] total_qwc,
    input  logic [SW-1:0] blk_size,
    input  logic [SW-1:0] gap_size,
    output logic          mode_ok,
    output logic          use_stride,
    output logic          len_bad
);
    import sdma_il_pkg::*;

    localparam int PADW = CW - SW;

    logic [CW-1:0] blk_ext;
    logic [CW-1:0] leftover;

    // Decide the mode class and check the block multiple.
    always_comb begin
        blk_ext    = {{PADW{1'b0}}, blk_size};
        mode_ok    = (mode == MODE_LINEAR) || (mode == MODE_STRIDE);
        use_stride = (mode == MODE_STRIDE) && scratch_ch &&
                     (blk_size != '0) && (gap_size != '0) && (total_qwc != '0);
        leftover   = use_stride ? (total_qwc % blk_ext) : '0;
        len_bad    = use_stride && (leftover != '0);
    end
endmodule

// File: rtl/sdma_ctrl.sv
// Phase controller: IDLE, XFER (waits for accept), SKIP (one cycle of address
// gap) and DONE (interrupt cycle). Assumes rem_zero reflects the count after
// the latest block update.
module sdma_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_ok,
    input  logic len_bad,
    input  logic stride_q,
    input  logic rem_zero,
    input  logic blk_ack,
    output logic load_o,
    output logic step_blk_o,
    output logic step_gap_o,
    output logic req_o,
    output logic busy_o,
    output logic irq_o,
    output logic err_o
);
    import sdma_il_pkg::*;

    seq_state_t state_q, state_d;
    logic       err_q;
    logic       start_seen;

    // Decode the strobes for the current phase.
    always_comb begin
        start_seen = start && (state_q == ST_IDLE) && mode_ok;
        load_o     = start_seen && !len_bad;
        req_o      = (state_q == ST_XFER);
        step_blk_o = (state_q == ST_XFER) && blk_ack;
        step_gap_o = (state_q == ST_SKIP);
        busy_o     = (state_q == ST_XFER) || (state_q == ST_SKIP);
        irq_o      = (state_q == ST_DONE);
        err_o      = err_q;
    end

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_o)     state_d = ST_XFER;
            ST_XFER: if (blk_ack)    state_d = stride_q ? ST_SKIP : ST_DONE;
            ST_SKIP:                 state_d = rem_zero ? ST_DONE : ST_XFER;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Phase and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_seen) err_q <= len_bad;
        end
    end

    AST_NO_GAP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        step_gap_o |-> !req_o); // R5
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && len_bad) |=> !busy_o); // R9
endmodule

// File: rtl/sdma_addr_path.sv
// Address and count registers. Loads the aligned start address and total on
// load, advances by a block on step_blk and by the gap on step_gap. Assumes
// AW > CW + 4 and CW > SW.
module sdma_addr_path #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_blk,
    input  logic          step_gap,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] total_qwc,
    input  logic [SW-1:0] blk_size,
    input  logic [SW-1:0] gap_size,
    input  logic          use_stride,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] rem_qwc,
    output logic [CW-1:0] blk_qwc,
    output logic          stride_q,
    output logic          rem_zero
);
    import sdma_il_pkg::*;

    localparam int PAD_C = AW - CW - QW_SHIFT;
    localparam int PAD_S = AW - SW - QW_SHIFT;
    localparam int PAD_B = CW - SW;

    logic [AW-1:0] addr_q;
    logic [CW-1:0] rem_q;
    logic [SW-1:0] blk_q, gap_q;
    logic          stride_r;
    logic [AW-1:0] blk_bytes, gap_bytes;

    // Size of the current block and the byte offsets it implies.
    always_comb begin
        if (stride_r)          blk_qwc = {{PAD_B{1'b0}}, blk_q};
        else if (rem_q == '0)  blk_qwc = {{(CW-1){1'b0}}, 1'b1};
        else                   blk_qwc = rem_q;
        blk_bytes = {{PAD_C{1'b0}}, blk_qwc, {QW_SHIFT{1'b0}}};
        gap_bytes = {{PAD_S{1'b0}}, gap_q, {QW_SHIFT{1'b0}}};
        cur_addr  = addr_q;
        rem_qwc   = rem_q;
        stride_q  = stride_r;
        rem_zero  = (rem_q == '0);
    end

    // Address, count and latched configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rem_q    <= '0;
            blk_q    <= '0;
            gap_q    <= '0;
            stride_r <= 1'b0;
        end else if (load) begin
            addr_q   <= {start_addr[AW-1:QW_SHIFT], {QW_SHIFT{1'b0}}};
            rem_q    <= total_qwc;
            blk_q    <= blk_size;
            gap_q    <= gap_size;
            stride_r <= use_stride;
        end else if (step_blk) begin
            addr_q   <= addr_q + blk_bytes;
            rem_q    <= rem_q - blk_qwc;
        end else if (step_gap) begin
            addr_q   <= addr_q + gap_bytes;
        end
    end

    AST_GAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_gap && !load) |=> $stable(rem_q)); // R5
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[QW_SHIFT-1:0] == '0); // R11
endmodule

// File: rtl/strided_dma_seq.sv
// Top of the strided interleave DMA sequencer. Checks the configuration,
// runs the phase controller and keeps the address and count. Assumes the
// data path holds blk_ack low except to accept a pending request.
module strided_dma_seq #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic          scratch_ch,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] total_qwc,
    input  logic [SW-1:0] blk_size,
    input  logic [SW-1:0] gap_size,
    output logic          blk_req,
    output logic [AW-1:0] blk_addr,
    output logic [CW-1:0] blk_qwc,
    input  logic          blk_ack,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] rem_qwc,
    output logic          busy,
    output logic          irq,
    output logic          len_err
);
    localparam int PAD_C = AW - CW - 4;

    logic mode_ok, use_stride, len_bad;
    logic load, step_blk, step_gap;
    logic stride_q, rem_zero;

    sdma_cfg_check #(.CW(CW), .SW(SW)) cfg_i (
        .mode(mode), .scratch_ch(scratch_ch), .total_qwc(total_qwc),
        .blk_size(blk_size), .gap_size(gap_size),
        .mode_ok(mode_ok), .use_stride(use_stride), .len_bad(len_bad)
    );

    sdma_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_ok(mode_ok),
        .len_bad(len_bad), .stride_q(stride_q), .rem_zero(rem_zero),
        .blk_ack(blk_ack), .load_o(load), .step_blk_o(step_blk),
        .step_gap_o(step_gap), .req_o(blk_req), .busy_o(busy),
        .irq_o(irq), .err_o(len_err)
    );

    sdma_addr_path #(.AW(AW), .CW(CW), .SW(SW)) path_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step_blk(step_blk),
        .step_gap(step_gap), .start_addr(start_addr), .total_qwc(total_qwc),
        .blk_size(blk_size), .gap_size(gap_size), .use_stride(use_stride),
        .cur_addr(cur_addr), .rem_qwc(rem_qwc), .blk_qwc(blk_qwc),
        .stride_q(stride_q), .rem_zero(rem_zero)
    );

    // The request address is always the running address.
    assign blk_addr = cur_addr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && !blk_ack) |=> (blk_req && $stable(blk_addr) && $stable(blk_qwc))); // R10
    AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && blk_ack) |=> (cur_addr == $past(blk_addr) + {{PAD_C{1'b0}}, $past(blk_qwc), 4'b0})); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R6
    AST_STRIDE_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stride_q) |-> (rem_qwc == '0)); // R6
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !blk_req); // R9
endmodule

// File: tb/strided_dma_seq_tb_top.sv
module strided_dma_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          scratch_ch = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] total_qwc = '0;
    logic [SW-1:0] blk_size = '0;
    logic [SW-1:0] gap_size = '0;
    logic          blk_ack = 1'b0;
    logic          blk_req, busy, irq, len_err;
    logic [AW-1:0] blk_addr, cur_addr;
    logic [CW-1:0] blk_qwc, rem_qwc;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strided_dma_seq #(.AW(AW), .CW(CW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .scratch_ch(scratch_ch), .start_addr(start_addr),
        .total_qwc(total_qwc), .blk_size(blk_size), .gap_size(gap_size),
        .blk_req(blk_req), .blk_addr(blk_addr), .blk_qwc(blk_qwc),
        .blk_ack(blk_ack), .cur_addr(cur_addr), .rem_qwc(rem_qwc),
        .busy(busy), .irq(irq), .len_err(len_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic go(input logic [1:0] m, input logic sc, input logic [31:0] a,
                      input logic [15:0] tot, input logic [7:0] b, input logic [7:0] g);
        mode = m; scratch_ch = sc; start_addr = a;
        total_qwc = tot; blk_size = b; gap_size = g;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 50 && !blk_req; i++) @(negedge clk);
        chk("R3", "request seen", {31'd0, blk_req}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "blk_req", {31'd0, blk_req}, 32'd0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        chk("R1", "len_err", {31'd0, len_err}, 32'd0);
        chk("R1", "cur_addr", cur_addr, 32'd0);
        chk("R1", "rem_qwc", {16'd0, rem_qwc}, 32'd0);
    endtask

    task automatic run_stride(input logic [31:0] a, input int tot,
                              input int b, input int g, input bit poke);
        logic [31:0] ea;
        int er;
        go(2'd2, 1'b1, a, tot[15:0], b[7:0], g[7:0]);
        chk("R9", "len_err cleared", {31'd0, len_err}, 32'd0);
        ea = a & 32'hFFFF_FFF0;
        er = tot;
        while (er != 0) begin
            wait_req();
            chk("R3", "blk_addr", blk_addr, ea);
            chk("R11", "blk_addr aligned", {28'd0, blk_addr[3:0]}, 32'd0);
            chk("R3", "blk_qwc", {16'd0, blk_qwc}, b);
            blk_ack = 1'b1;
            @(negedge clk);
            blk_ack = 1'b0;
            ea = ea + 32'(16 * b);
            er = er - b;
            chk("R4", "addr after block", cur_addr, ea);
            chk("R4", "rem after block", {16'd0, rem_qwc}, er);
            chk("R5", "no request in gap", {31'd0, blk_req}, 32'd0);
            if (poke && er != tot - b) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            ea = ea + 32'(16 * g);
            chk("R5", "addr after gap", cur_addr, ea);
            if (poke) chk("R2", "start while busy ignored", {16'd0, rem_qwc}, er);
        end
        chk("R6", "irq at end", {31'd0, irq}, 32'd1);
        chk("R6", "busy at end", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R6", "irq one cycle", {31'd0, irq}, 32'd0);
    endtask

    task automatic run_linear(input logic [1:0] m, input logic sc, input logic [31:0] a,
                              input int tot, input int b, input int g, input int hold);
        int q;
        logic [31:0] ea;
        go(m, sc, a, tot[15:0], b[7:0], g[7:0]);
        q  = (tot == 0) ? 1 : tot;
        ea = a & 32'hFFFF_FFF0;
        wait_req();
        chk("R7", "blk_addr", blk_addr, ea);
        chk("R7", "blk_qwc", {16'd0, blk_qwc}, q);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R10", "req held", {31'd0, blk_req}, 32'd1);
            chk("R10", "addr held", blk_addr, ea);
            chk("R10", "qwc held", {16'd0, blk_qwc}, q);
        end
        blk_ack = 1'b1;
        @(negedge clk);
        blk_ack = 1'b0;
        chk("R4", "addr after block", cur_addr, ea + 32'(16 * q));
        chk("R8", "rem after block", {16'd0, rem_qwc}, (tot - q) & 32'hFFFF);
        chk("R7", "single block then irq", {31'd0, irq}, 32'd1);
        chk("R6", "busy low at end", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R6", "irq one cycle", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ignored();
        logic [31:0] sa;
        logic [15:0] sr;
        sa = cur_addr; sr = rem_qwc;
        for (int m = 1; m < 4; m += 2) begin
            go(m[1:0], 1'b1, 32'h7700, 16'd4, 8'd2, 8'd1);
            chk("R2", "ignored mode busy", {31'd0, busy}, 32'd0);
            chk("R2", "ignored mode req", {31'd0, blk_req}, 32'd0);
            chk("R2", "ignored mode addr", cur_addr, sa);
            chk("R2", "ignored mode rem", {16'd0, rem_qwc}, {16'd0, sr});
        end
    endtask

    task automatic t_bad_len();
        logic [31:0] sa;
        logic [15:0] sr;
        sa = cur_addr; sr = rem_qwc;
        go(2'd2, 1'b1, 32'h2000, 16'd5, 8'd2, 8'd1);
        chk("R9", "len_err set", {31'd0, len_err}, 32'd1);
        chk("R9", "busy low", {31'd0, busy}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "no request", {31'd0, blk_req}, 32'd0);
        end
        chk("R9", "addr untouched", cur_addr, sa);
        chk("R9", "rem untouched", {16'd0, rem_qwc}, {16'd0, sr});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_stride(32'h0000_1000, 6, 2, 3, 1'b0);
        run_stride(32'h0000_400C, 9, 3, 1, 1'b1);
        run_stride(32'h0000_8000, 4, 4, 5, 1'b0);
        run_linear(2'd0, 1'b0, 32'h0000_3000, 7, 2, 3, 3);
        run_linear(2'd2, 1'b1, 32'h0000_5000, 6, 2, 0, 0);
        run_linear(2'd2, 1'b1, 32'h0000_5100, 6, 0, 2, 0);
        run_linear(2'd2, 1'b0, 32'h0000_5208, 6, 2, 2, 1);
        run_linear(2'd0, 1'b1, 32'h0000_6000, 0, 2, 2, 0);
        t_ignored();
        t_bad_len();
        run_linear(2'd0, 1'b0, 32'h0000_A000, 3, 0, 0, 0);
        chk("R9", "len_err cleared by good start", {31'd0, len_err}, 32'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule